// File: doc/BRIEF.md
# Fifth-Order Sinc Decimation Filter

This block converts the single-bit output of a delta-sigma modulator into signed multi-bit conversion words. It runs from one system clock. It divides that clock by six to make a modulator-rate enable, and it takes one modulator bit on each enable. A one is weighed as +1 and a zero as -1. The bits pass through five cascaded 64-sample moving sums, built as five integrators at the modulator rate, a 64:1 decimation and five first-difference stages at the output rate. One word comes out for every 64 modulator samples, so the word rate is the system clock divided by 384.

The raw sum carries a gain of 64 to the fifth power. The output word is scaled so that a constant input maps to plus or minus one quarter of the word's range. A one-cycle strobe marks each new word, and the word holds until the next strobe. A settled flag tells the host when a word is free of history from before the last restart. After a reset it rises on the fifth word. After a host-signalled input step, which can land at any phase of the conversion, it rises on the sixth word.

Top module: `sinc5_decimator`

## Requirements
- R1: A modulator bit is sampled on every sixth clock edge after reset release. With the first low-reset edge counted as edge 1, the first strobe is visible after edge 385, and each later strobe follows the previous one by exactly 384 clocks.
- R2: Each output word equals floor(S / 256). S is the convolution of the ±1 sample sequence with the fifth power of a 64-tap all-ones box, taken up to and including the newest sample. Samples from before the last reset count as 0.
- R3: With a constant input, once settled, all ones give +4194304 (2^22) and all zeros give -4194304. A repeating pattern of three ones and one zero gives +2097152. Every word stays within ±2^22.
- R4: With alternating ones and zeros, the settled word is exactly 0.
- R5: `result_valid` is high for exactly one clock per word, in the cycle the new word first appears. `result` does not change while `result_valid` is low.
- R6: After reset, `settled` is low for the first four words and rises together with the strobe of the fifth word (edge 1921). It changes only on a strobe edge.
- R7: A one-cycle `rearm` pulse drives `settled` low on the next edge. `settled` rises again with the sixth strobe after the pulse. The words themselves are not affected.
- R8: While `rst` is high, `result`, `result_valid` and `settled` are 0. Reset clears all filter history, so the first word after a reset in the middle of a run depends only on samples taken after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_bit | input | 1 | Modulator bit (1 weighs +1, 0 weighs -1) |
| rearm | input | 1 | One-cycle pulse marking an input step at any phase |
| result | output | 24 | Signed conversion word, Q2.22 |
| result_valid | output | 1 | One-cycle strobe for a new word |
| settled | output | 1 | High once words are free of pre-restart history |

## Verification
The steady patterns show whether the gain is right. All ones and all zeros pin both ends of the scale. The three-ones-in-four pattern checks a mid-scale value that the shift must not round away. The alternating pattern must cancel to exactly zero, which catches a box of the wrong length or a sign slip in one stage. A step and an irregular pseudo-random stream are compared word by word against a convolution model. These catch wrong stage ordering, a wrong differential delay or a misplaced sample, which the constant patterns cannot. A restart in the middle of a run and a rearm pulse separate stale filter history from the two settling counts.

// File: rtl/sinc5_pkg.sv
package sinc5_pkg;

    localparam int SINC_ORDER  = 5;
    localparam int DECIM_RATIO = 64;
    localparam int CLK_DIV     = 6;
    localparam int RESULT_W    = 24;

    // Kind of restart that starts a settling count
    typedef enum logic {
        RESTART_SYNC,
        RESTART_ASYNC
    } restart_e;

    // Events seen by the settling tracker
    typedef struct packed {
        logic conv_tick;
        logic rearm;
    } settle_evt_t;

    // Words needed before output is free of old history
    function automatic int settle_target(input int order, input restart_e kind);
        return (kind == RESTART_ASYNC) ? order + 1 : order;
    endfunction

endpackage

// File: rtl/sinc5_clk_div.sv
module sinc5_clk_div #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst,
    output logic mod_en
);
    generate
        if (DIV <= 1) begin : g_passthru
            assign mod_en = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst)              cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end

            assign mod_en = (cnt == LAST);

            // R1: enables are isolated single cycles
            assert_en_spacing_R1: assert property (@(posedge clk) disable iff (rst)
                mod_en |=> !mod_en);
        end
    endgenerate
endmodule

// File: rtl/sinc5_integrators.sv
module sinc5_integrators #(
    parameter int ORDER = 5,
    parameter int DECIM = 64,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mod_en,
    input  logic                    mod_bit,
    output logic                    dec_tick,
    output logic signed [ACC_W-1:0] dec_sample
);
    localparam int CNT_W = $clog2(DECIM);
    localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(DECIM - 1);

    logic signed [ACC_W-1:0] integ     [ORDER];
    logic signed [ACC_W-1:0] integ_nxt [ORDER];
    logic signed [ACC_W-1:0] step_in;
    logic [CNT_W-1:0]        phase;

    // +1 for a one, -1 (all ones) for a zero
    assign step_in = {{(ACC_W-1){~mod_bit}}, 1'b1};

    always_comb begin
        integ_nxt[0] = integ[0] + step_in;
        for (int k = 1; k < ORDER; k++)
            integ_nxt[k] = integ[k] + integ_nxt[k-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < ORDER; k++) integ[k] <= '0;
        end else if (mod_en) begin
            for (int k = 0; k < ORDER; k++) integ[k] <= integ_nxt[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= '0;
            dec_tick   <= 1'b0;
            dec_sample <= '0;
        end else begin
            dec_tick <= mod_en && (phase == LAST_PHASE);
            if (mod_en) begin
                phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
                if (phase == LAST_PHASE)
                    dec_sample <= integ_nxt[ORDER-1];
            end
        end
    end

    // R1: a decimated sample always follows a modulator enable
    assert_tick_after_en_R1: assert property (@(posedge clk) disable iff (rst)
        dec_tick |-> $past(mod_en));
endmodule

// File: rtl/sinc5_combs.sv
module sinc5_combs #(
    parameter int ORDER     = 5,
    parameter int ACC_W     = 32,
    parameter int OUT_W     = 24,
    parameter int OUT_SHIFT = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    dec_tick,
    input  logic signed [ACC_W-1:0] dec_sample,
    output logic        [OUT_W-1:0] result,
    output logic                    result_valid
);
    localparam int FULL_SCALE = 2 ** (OUT_W - 2);

    logic signed [ACC_W-1:0] hist [ORDER];
    logic signed [ACC_W-1:0] diff [ORDER];

    always_comb begin
        diff[0] = dec_sample - hist[0];
        for (int k = 1; k < ORDER; k++)
            diff[k] = diff[k-1] - hist[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < ORDER; k++) hist[k] <= '0;
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= dec_tick;
            if (dec_tick) begin
                hist[0] <= dec_sample;
                for (int k = 1; k < ORDER; k++) hist[k] <= diff[k-1];
                result <= OUT_W'(diff[ORDER-1] >>> OUT_SHIFT);
            end
        end
    end

    // R5: strobe lasts one cycle
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R5: word holds between strobes
    assert_word_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result));

    // R3: unity gain bounds every word
    assert_word_range_R3: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> ($signed(result) <= FULL_SCALE && $signed(result) >= -FULL_SCALE));
endmodule

// File: rtl/sinc5_settle.sv
module sinc5_settle
    import sinc5_pkg::*;
#(
    parameter int ORDER = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  settle_evt_t evt,
    output logic        settled
);
    localparam int SYNC_N  = settle_target(ORDER, RESTART_SYNC);
    localparam int ASYNC_N = settle_target(ORDER, RESTART_ASYNC);
    localparam int CW      = $clog2(ASYNC_N + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)                                 left <= CW'(SYNC_N);
        else if (evt.rearm)                      left <= CW'(ASYNC_N);
        else if (evt.conv_tick && left != '0)    left <= left - 1'b1;
    end

    assign settled = (left == '0);

    // R7: rearm clears the flag on the next edge
    assert_rearm_drop_R7: assert property (@(posedge clk) disable iff (rst)
        evt.rearm |=> !settled);

    // R6: the flag only rises on a conversion edge
    assert_rise_on_conv_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(settled) |-> $past(evt.conv_tick));
endmodule

// File: rtl/sinc5_decimator.sv
module sinc5_decimator
    import sinc5_pkg::*;
#(
    parameter int DIV_RATIO = CLK_DIV,
    parameter int DECIM     = DECIM_RATIO,
    parameter int ORDER     = SINC_ORDER,
    parameter int OUT_W     = RESULT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_bit,
    input  logic             rearm,
    output logic [OUT_W-1:0] result,
    output logic             result_valid,
    output logic             settled
);
    localparam int GAIN_SHIFT = ORDER * $clog2(DECIM);
    localparam int ACC_W      = GAIN_SHIFT + 2;
    localparam int OUT_SHIFT  = GAIN_SHIFT - (OUT_W - 2);

    logic                    mod_en;
    logic                    dec_tick;
    logic signed [ACC_W-1:0] dec_sample;
    settle_evt_t             evt;

    sinc5_clk_div #(.DIV(DIV_RATIO)) u_div (
        .clk    (clk),
        .rst    (rst),
        .mod_en (mod_en)
    );

    sinc5_integrators #(.ORDER(ORDER), .DECIM(DECIM), .ACC_W(ACC_W)) u_integ (
        .clk        (clk),
        .rst        (rst),
        .mod_en     (mod_en),
        .mod_bit    (mod_bit),
        .dec_tick   (dec_tick),
        .dec_sample (dec_sample)
    );

    sinc5_combs #(.ORDER(ORDER), .ACC_W(ACC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) u_comb (
        .clk          (clk),
        .rst          (rst),
        .dec_tick     (dec_tick),
        .dec_sample   (dec_sample),
        .result       (result),
        .result_valid (result_valid)
    );

    assign evt.conv_tick = dec_tick;
    assign evt.rearm     = rearm;

    sinc5_settle #(.ORDER(ORDER)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .settled (settled)
    );

    // R6: the flag rises together with a word strobe
    assert_settle_with_word_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(settled) |-> result_valid);

    // R1: every word is produced one edge after a decimated sample
    assert_word_follows_tick_R1: assert property (@(posedge clk) disable iff (rst)
        dec_tick |=> result_valid);
endmodule

// File: tb/sinc5_decimator_test.sv
module sinc5_decimator_test;
    localparam int TAPS = 316;

    typedef struct packed {
        int pat;
        int has_exp;
        int exp_val;
        int req;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{0, 1,  4194304, 3},
        '{1, 1, -4194304, 3},
        '{2, 1,        0, 4},
        '{3, 1,  2097152, 3},
        '{4, 0,        0, 2},
        '{5, 0,        0, 2}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        mod_bit = 1'b0;
    logic        rearm;
    logic [23:0] result;
    logic        result_valid;
    logic        settled;

    int  cyc = 0;
    int  pat_sel = 0;
    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    int  h [TAPS];

    sinc5_decimator uut (
        .clk          (clk),
        .rst          (rst),
        .mod_bit      (mod_bit),
        .rearm        (rearm),
        .result       (result),
        .result_valid (result_valid),
        .settled      (settled)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic bit pat(input int id, input int j);
        case (id)
            0:       return 1'b1;
            1:       return 1'b0;
            2:       return j[0];
            3:       return (j % 4) != 3;
            4:       return j < 150;
            default: return ((j * 13 + j / 7) % 5) < 2;
        endcase
    endfunction

    always @(negedge clk) mod_bit <= pat(pat_sel, cyc / 6);

    function automatic longint model(input int id, input int m);
        longint acc = 0;
        for (int k = 0; k < TAPS; k++) begin
            int idx = 64 * m - 1 - k;
            if (idx >= 0) acc += pat(id, idx) ? longint'(h[k]) : -longint'(h[k]);
        end
        return acc >>> 8;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (!result_valid);
    endtask

    task automatic apply_reset(input int p);
        @(negedge clk);
        rst = 1'b1;
        pat_sel = p;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int a [TAPS];
        int t [TAPS];
        for (int k = 0; k < TAPS; k++) a[k] = (k < 64) ? 1 : 0;
        for (int s = 1; s < 5; s++) begin
            for (int k = 0; k < TAPS; k++) begin
                t[k] = 0;
                for (int i = 0; i < 64; i++)
                    if (k - i >= 0) t[k] += a[k - i];
            end
            a = t;
        end
        h = a;

        rst = 1'b1;
        rearm = 1'b0;
        repeat (3) @(negedge clk);
        // R8: outputs cleared in reset
        check(result == 0, "R8 result in reset", longint'(result), 0);
        check(result_valid == 0, "R8 strobe in reset", longint'(result_valid), 0);
        check(settled == 0, "R8 settled in reset", longint'(settled), 0);
        rst = 1'b0;

        // Table walk: each row restarts and runs eight words
        for (int r = 0; r < 6; r++) begin
            string tag;
            longint prev;
            apply_reset(VECS[r].pat);
            tag = (VECS[r].req == 4) ? "R4" : (VECS[r].req == 3) ? "R3" : "R2";
            for (int m = 1; m <= 8; m++) begin
                wait_strobe();
                check(cyc == 385 + 384 * (m - 1), "R1 strobe timing", cyc, 385 + 384 * (m - 1));
                check(longint'($signed(result)) == model(VECS[r].pat, m), "R2 word value",
                      longint'($signed(result)), model(VECS[r].pat, m));
                check(settled == (m >= 5), "R6 settled flag", longint'(settled), longint'(m >= 5));
                if (VECS[r].has_exp != 0 && m >= 5)
                    check(longint'($signed(result)) == longint'(VECS[r].exp_val), tag,
                          longint'($signed(result)), longint'(VECS[r].exp_val));
                prev = longint'($signed(result));
                @(negedge clk);
                check(result_valid == 0, "R5 strobe width", longint'(result_valid), 0);
                check(longint'($signed(result)) == prev, "R5 word hold", longint'($signed(result)), prev);
            end
        end

        // R8: reset in the middle of a run clears history
        apply_reset(0);
        repeat (3) wait_strobe();
        apply_reset(1);
        wait_strobe();
        check(cyc == 385, "R8 first strobe after restart", cyc, 385);
        check(longint'($signed(result)) == model(1, 1), "R8 history cleared",
              longint'($signed(result)), model(1, 1));
        check(settled == 0, "R8 settled after restart", longint'(settled), 0);

        // R7: rearm pulse restarts a six-word settling count
        apply_reset(5);
        repeat (6) wait_strobe();
        check(settled == 1, "R7 settled before rearm", longint'(settled), 1);
        repeat (100) @(negedge clk);
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
        check(settled == 0, "R7 settled drop", longint'(settled), 0);
        for (int s = 1; s <= 6; s++) begin
            wait_strobe();
            check(longint'($signed(result)) == model(5, 6 + s), "R7 words unaffected",
                  longint'($signed(result)), model(5, 6 + s));
            check(settled == (s == 6), "R7 settled after rearm", longint'(settled), longint'(s == 6));
        end

        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule